// File: doc/BRIEF.md
# Counted Breakpoint and Run Control Unit

This unit watches a processor's instruction-fetch and data-access buses. It has two comparators on the fetch address and one on the data address. Each comparator holds a target address and an occurrence count N. It fires on every Nth qualifying match, then reloads N and counts again.

Each comparator is set either as a breakpoint or as a watchpoint. A breakpoint firing halts the core by dropping the core clock enable. A watchpoint firing only raises a one-cycle event. The halt is also entered on an explicit debug request, or out of reset when a strap input asks for it. A resume input leaves the halted state.

While the core runs, a trace counter counts fetched instructions. On each taken branch or exception it emits a record. The record holds the count since the previous record and a flag that tells an exception from a branch. The count then clears. A debug host programs the comparators through a simple register write port.

Top module: `bkpt_run_ctrl`

## Requirements
- R1: After reset every comparator is disabled with N equal to 1, no event or trace record is pending, and `core_clk_en` is always the inverse of `halted`.
- R2: The write port selects a comparator with `cfg_addr[3:2]` and a field with `cfg_addr[1:0]`. Field 0 is the match address. Field 1 is the count N, taken from `cfg_wdata[7:0]`. Field 2 is control: bit 0 enables, bit 1 selects watchpoint (1) or breakpoint (0). Field 3 and comparator index 3 are ignored. Comparators 0 and 1 match `ifetch_addr` when `ifetch_valid` is high. Comparator 2 matches `dacc_addr` when `dacc_valid` is high.
- R3: An enabled comparator fires on the Nth match and reloads N after firing, so it fires on every Nth match. A written N of 0 acts as 1.
- R4: Writing N restarts the countdown from the new N. A match in the same cycle as that write is not counted.
- R5: A breakpoint firing makes `halted` high in the cycle after the match.
- R6: A watchpoint firing raises the event but leaves the core running.
- R7: `evt_hit` is high for exactly the cycle after any comparator fires. `hit_mask` bit k marks that comparator k fired.
- R8: While the core runs, `debug_req` halts it in the next cycle. While halted, `resume` without `debug_req` restarts it in the next cycle. `debug_req` wins over `resume`, and `resume` while running has no effect.
- R9: While halted, bus strobes and branch or exception indications are ignored: nothing is counted, fired or traced.
- R10: While running, each cycle with `ifetch_valid` adds one to the instruction count. On `br_taken` or `exc_taken`, the next cycle shows `trc_valid` with `trc_count` equal to the fetches since the last record, including the current cycle. `trc_exc` is 1 when `exc_taken` was high. The count then clears. It saturates at 2^ICNT_W-1.
- R11: With `reset_halt_en` high during reset, the unit leaves reset halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reset_halt_en | input | 1 | Start halted out of reset |
| ifetch_valid | input | 1 | Instruction fetch strobe |
| ifetch_addr | input | ADDR_W | Instruction fetch address |
| dacc_valid | input | 1 | Data access strobe |
| dacc_addr | input | ADDR_W | Data access address |
| br_taken | input | 1 | Taken branch indication |
| exc_taken | input | 1 | Exception indication |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Comparator index and field |
| cfg_wdata | input | ADDR_W | Register write data |
| debug_req | input | 1 | Request to halt |
| resume | input | 1 | Request to leave halt |
| core_clk_en | output | 1 | Core clock enable |
| halted | output | 1 | Debug-mode halt state |
| evt_hit | output | 1 | One-cycle hit event |
| hit_mask | output | NCMP | Comparators that fired |
| trc_valid | output | 1 | Trace record strobe |
| trc_count | output | ICNT_W | Instructions since previous record |
| trc_exc | output | 1 | Record caused by an exception |

## Verification
Every result of this unit is due exactly one clock after the edge that samples its cause: a hit event, a halt from a breakpoint or request, a resume, and a trace record. The bench drives stimulus on the falling edge and steps its behavioural model on the rising edge. It then compares `halted`, `core_clk_en`, `evt_hit`, `hit_mask` and the trace fields at the following falling edge. Directed checks read the outputs at that same falling edge after each single-cycle stimulus, using hand-worked values for the Nth-match, restart, halt-ignore and saturation cases.

// File: rtl/bkpt_pkg.sv
`timescale 1ns/1ps
package bkpt_pkg;
    typedef enum logic {
        RC_RUN  = 1'b0,
        RC_HALT = 1'b1
    } run_state_e;

    localparam logic [1:0] FLD_ADDR  = 2'd0;
    localparam logic [1:0] FLD_COUNT = 2'd1;
    localparam logic [1:0] FLD_CTRL  = 2'd2;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_WATCH_BIT = 1;
endpackage

// File: rtl/match_counter.sv
`timescale 1ns/1ps
module match_counter #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr,
    input  logic              wr_count,
    input  logic              wr_ctrl,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              active,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              fire,
    output logic              watch
);
    import bkpt_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] cmp;
        logic [CNT_W-1:0]  n;
        logic [CNT_W-1:0]  remain;
        logic              en;
        logic              watch;
    } mc_state_t;

    mc_state_t        s_d, s_q;
    logic             hit;
    logic [CNT_W-1:0] n_new;

    always_comb begin
        s_d   = s_q;
        fire  = 1'b0;
        hit   = active && s_q.en && bus_valid && (bus_addr == s_q.cmp);
        n_new = (wdata[CNT_W-1:0] == '0) ? ONE : wdata[CNT_W-1:0];
        if (wr_count) begin
            s_d.n      = n_new;
            s_d.remain = n_new;
        end else if (hit) begin
            if (s_q.remain == ONE) begin
                fire       = 1'b1;
                s_d.remain = s_q.n;
            end else begin
                s_d.remain = s_q.remain - ONE;
            end
        end
        if (wr_addr) begin
            s_d.cmp = wdata;
        end
        if (wr_ctrl) begin
            s_d.en    = wdata[CTRL_EN_BIT];
            s_d.watch = wdata[CTRL_WATCH_BIT];
        end
    end

    assign watch = s_q.watch;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.cmp    <= '0;
            s_q.n      <= ONE;
            s_q.remain <= ONE;
            s_q.en     <= 1'b0;
            s_q.watch  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_REMAIN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        s_q.remain != '0); // R3
    AST_FIRE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        fire |=> (s_q.remain == s_q.n)); // R3
    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
        wr_count |=> (s_q.remain == s_q.n)); // R4
    AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
        (!active || !bus_valid) |-> !fire); // R9
endmodule

// File: rtl/halt_ctrl.sv
`timescale 1ns/1ps
module halt_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic reset_halt_en,
    input  logic bp_fire,
    input  logic debug_req,
    input  logic resume,
    output logic halted
);
    import bkpt_pkg::*;

    typedef struct packed {
        run_state_e st;
    } hc_state_t;

    hc_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            RC_RUN: begin
                if (debug_req || bp_fire) begin
                    s_d.st = RC_HALT;
                end
            end
            RC_HALT: begin
                if (resume && !debug_req) begin
                    s_d.st = RC_RUN;
                end
            end
            default: s_d.st = RC_HALT;
        endcase
    end

    assign halted = (s_q.st == RC_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.st <= reset_halt_en ? RC_HALT : RC_RUN;
        end else begin
            s_q <= s_d;
        end
    end

    AST_BP_HALTS: assert property (@(posedge clk) disable iff (rst)
        bp_fire |=> halted); // R5
    AST_REQ_HALTS: assert property (@(posedge clk) disable iff (rst)
        debug_req |=> halted); // R8
    AST_RESUME_RUNS: assert property (@(posedge clk) disable iff (rst)
        (halted && resume && !debug_req) |=> !halted); // R8
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (halted && !resume) |=> halted); // R8
endmodule

// File: rtl/branch_trace.sv
`timescale 1ns/1ps
module branch_trace #(
    parameter int ICNT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              fetch,
    input  logic              br,
    input  logic              exc,
    output logic              trc_valid,
    output logic [ICNT_W-1:0] trc_count,
    output logic              trc_exc
);
    localparam logic [ICNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [ICNT_W-1:0] icnt;
        logic              valid;
        logic [ICNT_W-1:0] cnt;
        logic              exc;
    } bt_state_t;

    bt_state_t         s_d, s_q;
    logic [ICNT_W:0]   inc;
    logic [ICNT_W-1:0] sat;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        inc       = {1'b0, s_q.icnt} + {{ICNT_W{1'b0}}, fetch};
        sat       = inc[ICNT_W] ? CNT_MAX : inc[ICNT_W-1:0];
        if (active) begin
            if (br || exc) begin
                s_d.valid = 1'b1;
                s_d.cnt   = sat;
                s_d.exc   = exc;
                s_d.icnt  = '0;
            end else begin
                s_d.icnt  = sat;
            end
        end
    end

    assign trc_valid = s_q.valid;
    assign trc_count = s_q.cnt;
    assign trc_exc   = s_q.exc;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_TRACE_EMIT: assert property (@(posedge clk) disable iff (rst)
        (active && (br || exc)) |=> trc_valid); // R10
    AST_TRACE_QUIET_HALT: assert property (@(posedge clk) disable iff (rst)
        !active |=> !trc_valid); // R9
    AST_TRACE_EXC_FLAG: assert property (@(posedge clk) disable iff (rst)
        (active && exc) |=> trc_exc); // R10
endmodule

// File: rtl/bkpt_run_ctrl.sv
`timescale 1ns/1ps
module bkpt_run_ctrl #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int ICNT_W = 10,
    parameter int N_IBP  = 2,
    parameter int N_DBP  = 1,
    localparam int NCMP   = N_IBP + N_DBP,
    localparam int SEL_W  = (NCMP > 1) ? $clog2(NCMP) : 1,
    localparam int CFG_AW = SEL_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reset_halt_en,
    input  logic              ifetch_valid,
    input  logic [ADDR_W-1:0] ifetch_addr,
    input  logic              dacc_valid,
    input  logic [ADDR_W-1:0] dacc_addr,
    input  logic              br_taken,
    input  logic              exc_taken,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              debug_req,
    input  logic              resume,
    output logic              core_clk_en,
    output logic              halted,
    output logic              evt_hit,
    output logic [NCMP-1:0]   hit_mask,
    output logic              trc_valid,
    output logic [ICNT_W-1:0] trc_count,
    output logic              trc_exc
);
    import bkpt_pkg::*;

    typedef struct packed {
        logic            evt;
        logic [NCMP-1:0] mask;
    } hit_state_t;

    logic [NCMP-1:0] fire_vec;
    logic [NCMP-1:0] watch_vec;
    logic            bp_any;
    logic            active;
    logic [SEL_W-1:0] cfg_sel;
    logic [1:0]       cfg_fld;
    hit_state_t       h_d, h_q;

    assign active  = !halted;
    assign cfg_sel = cfg_addr[CFG_AW-1:2];
    assign cfg_fld = cfg_addr[1:0];

    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        logic              sel_k;
        logic              v_k;
        logic [ADDR_W-1:0] a_k;

        assign sel_k = cfg_we && (cfg_sel == SEL_W'(k));

        if (k < N_IBP) begin : g_ibus
            assign v_k = ifetch_valid;
            assign a_k = ifetch_addr;
        end else begin : g_dbus
            assign v_k = dacc_valid;
            assign a_k = dacc_addr;
        end

        match_counter #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W)
        ) u_mc (
            .clk       (clk),
            .rst       (rst),
            .wr_addr   (sel_k && (cfg_fld == FLD_ADDR)),
            .wr_count  (sel_k && (cfg_fld == FLD_COUNT)),
            .wr_ctrl   (sel_k && (cfg_fld == FLD_CTRL)),
            .wdata     (cfg_wdata),
            .active    (active),
            .bus_valid (v_k),
            .bus_addr  (a_k),
            .fire      (fire_vec[k]),
            .watch     (watch_vec[k])
        );
    end

    assign bp_any = |(fire_vec & ~watch_vec);

    halt_ctrl u_halt (
        .clk           (clk),
        .rst           (rst),
        .reset_halt_en (reset_halt_en),
        .bp_fire       (bp_any),
        .debug_req     (debug_req),
        .resume        (resume),
        .halted        (halted)
    );

    branch_trace #(
        .ICNT_W (ICNT_W)
    ) u_trace (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .fetch     (ifetch_valid),
        .br        (br_taken),
        .exc       (exc_taken),
        .trc_valid (trc_valid),
        .trc_count (trc_count),
        .trc_exc   (trc_exc)
    );

    always_comb begin
        h_d      = h_q;
        h_d.evt  = |fire_vec;
        h_d.mask = fire_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign evt_hit     = h_q.evt;
    assign hit_mask    = h_q.mask;
    assign core_clk_en = !halted;

    AST_HALT_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        halted |=> !evt_hit); // R9
    AST_WATCH_NO_HALT: assert property (@(posedge clk) disable iff (rst)
        (!halted && (fire_vec != '0) && !bp_any && !debug_req) |=> !halted); // R6
    AST_EVT_PULSE: assert property (@(posedge clk) disable iff (rst)
        (fire_vec == '0) |=> !evt_hit); // R7
    AST_MASK_MATCH: assert property (@(posedge clk) disable iff (rst)
        evt_hit |-> (hit_mask != '0)); // R7
endmodule

// File: tb/bkpt_run_ctrl_bench.sv
`timescale 1ns/1ps
module bkpt_run_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam int CMAX       = 1023;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reset_halt_en = 1'b1;
    logic        ifetch_valid = 1'b0;
    logic [15:0] ifetch_addr = '0;
    logic        dacc_valid = 1'b0;
    logic [15:0] dacc_addr = '0;
    logic        br_taken = 1'b0;
    logic        exc_taken = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        debug_req = 1'b0;
    logic        resume = 1'b0;
    logic        core_clk_en;
    logic        halted;
    logic        evt_hit;
    logic [2:0]  hit_mask;
    logic        trc_valid;
    logic [9:0]  trc_count;
    logic        trc_exc;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    bkpt_run_ctrl u_bkpt_run_ctrl (
        .clk(clk), .rst(rst), .reset_halt_en(reset_halt_en),
        .ifetch_valid(ifetch_valid), .ifetch_addr(ifetch_addr),
        .dacc_valid(dacc_valid), .dacc_addr(dacc_addr),
        .br_taken(br_taken), .exc_taken(exc_taken),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .debug_req(debug_req), .resume(resume),
        .core_clk_en(core_clk_en), .halted(halted),
        .evt_hit(evt_hit), .hit_mask(hit_mask),
        .trc_valid(trc_valid), .trc_count(trc_count), .trc_exc(trc_exc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [15:0] m_cmp [3];
    int  m_n [3];
    int  m_rem [3];
    bit  m_en [3];
    bit  m_w [3];
    bit  m_halted;
    int  m_icnt;
    bit  m_evt;
    int  m_mask;
    bit  m_trv;
    int  m_trc;
    bit  m_tre;

    always @(posedge clk) begin
        if (rst) begin
            m_halted = reset_halt_en;
            m_evt = 0; m_mask = 0; m_trv = 0; m_trc = 0; m_tre = 0; m_icnt = 0;
            for (int k = 0; k < 3; k++) begin
                m_cmp[k] = '0; m_n[k] = 1; m_rem[k] = 1; m_en[k] = 0; m_w[k] = 0;
            end
        end else begin
            bit act;
            bit bpany;
            int mask;
            act = !m_halted;
            bpany = 0;
            mask = 0;
            for (int k = 0; k < 3; k++) begin
                bit v;
                bit hitk;
                bit wsel;
                logic [15:0] a;
                v = (k < 2) ? ifetch_valid : dacc_valid;
                a = (k < 2) ? ifetch_addr : dacc_addr;
                wsel = cfg_we && (int'(cfg_addr[3:2]) == k);
                hitk = act && m_en[k] && v && (a == m_cmp[k]);
                if (wsel && cfg_addr[1:0] == 2'd1) begin
                    int nn;
                    nn = int'(cfg_wdata[7:0]);
                    if (nn == 0) nn = 1;
                    m_n[k] = nn;
                    m_rem[k] = nn;
                end else if (hitk) begin
                    if (m_rem[k] == 1) begin
                        mask = mask | (1 << k);
                        if (!m_w[k]) bpany = 1;
                        m_rem[k] = m_n[k];
                    end else begin
                        m_rem[k] = m_rem[k] - 1;
                    end
                end
                if (wsel && cfg_addr[1:0] == 2'd0) m_cmp[k] = cfg_wdata;
                if (wsel && cfg_addr[1:0] == 2'd2) begin
                    m_en[k] = cfg_wdata[0];
                    m_w[k] = cfg_wdata[1];
                end
            end
            m_evt = (mask != 0);
            m_mask = mask;
            m_trv = 0;
            if (act) begin
                int s;
                s = m_icnt + int'(ifetch_valid);
                if (s > CMAX) s = CMAX;
                if (br_taken || exc_taken) begin
                    m_trv = 1; m_trc = s; m_tre = exc_taken; m_icnt = 0;
                end else begin
                    m_icnt = s;
                end
            end
            if (!m_halted) begin
                if (debug_req || bpany) m_halted = 1;
            end else if (resume && !debug_req) begin
                m_halted = 0;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R5 R8 halted vs model", int'(halted), int'(m_halted));
            chk("R1 core_clk_en vs model", int'(core_clk_en), int'(!m_halted));
            chk("R7 evt_hit vs model", int'(evt_hit), int'(m_evt));
            chk("R7 hit_mask vs model", int'(hit_mask), m_mask);
            chk("R10 trc_valid vs model", int'(trc_valid), int'(m_trv));
            if (m_trv) begin
                chk("R10 trc_count vs model", int'(trc_count), m_trc);
                chk("R10 trc_exc vs model", int'(trc_exc), int'(m_tre));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg(input int sel, input int fld, input int data);
        cfg_we = 1'b1;
        cfg_addr = 4'((sel << 2) | fld);
        cfg_wdata = 16'(data);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic fetch(input int addr);
        ifetch_valid = 1'b1;
        ifetch_addr = 16'(addr);
        tick();
        ifetch_valid = 1'b0;
    endtask

    task automatic daccess(input int addr);
        dacc_valid = 1'b1;
        dacc_addr = 16'(addr);
        tick();
        dacc_valid = 1'b0;
    endtask

    task automatic pulse_resume();
        resume = 1'b1;
        tick();
        resume = 1'b0;
    endtask

    initial begin
        // Reset with halt strap set
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11 halted out of reset", int'(halted), 1);
        chk("R1 core_clk_en low while halted", int'(core_clk_en), 0);
        chk("R1 no event after reset", int'(evt_hit), 0);
        chk("R1 no trace after reset", int'(trc_valid), 0);
        pulse_resume();
        chk("R8 resume leaves halt", int'(halted), 0);
        chk("R8 core clock re-enabled", int'(core_clk_en), 1);
        fetch('h0);
        chk("R1 comparators disabled after reset", int'(evt_hit), 0);

        // Breakpoint on the 3rd fetch of 0x100
        cfg(0, 0, 'h100);
        cfg(0, 1, 3);
        cfg(0, 2, 1);
        fetch('h100);
        chk("R3 first match no fire", int'(evt_hit), 0);
        fetch('h104);
        fetch('h100);
        chk("R3 second match no fire", int'(evt_hit), 0);
        fetch('h100);
        chk("R3 third match fires", int'(evt_hit), 1);
        chk("R7 mask comparator 0", int'(hit_mask), 1);
        chk("R5 breakpoint halts", int'(halted), 1);
        tick();
        chk("R7 event lasts one cycle", int'(evt_hit), 0);
        pulse_resume();
        fetch('h100);
        fetch('h100);
        chk("R3 reload not yet due", int'(evt_hit), 0);
        fetch('h100);
        chk("R3 fires again after reload", int'(evt_hit), 1);
        pulse_resume();

        // Data watchpoint on comparator 2
        cfg(2, 0, 'h2000);
        cfg(2, 1, 1);
        cfg(2, 2, 3);
        fetch('h2000);
        chk("R2 data comparator ignores fetch bus", int'(evt_hit), 0);
        daccess('h2000);
        chk("R6 watchpoint event", int'(evt_hit), 1);
        chk("R2 mask comparator 2", int'(hit_mask), 4);
        chk("R6 watchpoint does not halt", int'(halted), 0);

        // Restart by rewriting N on comparator 1 (watch)
        cfg(1, 0, 'h300);
        cfg(1, 1, 2);
        cfg(1, 2, 3);
        fetch('h300);
        cfg(1, 1, 2);
        fetch('h300);
        chk("R4 rewrite restarts countdown", int'(evt_hit), 0);
        fetch('h300);
        chk("R4 fires after full N", int'(evt_hit), 1);
        chk("R7 mask comparator 1", int'(hit_mask), 2);
        fetch('h300);
        cfg_we = 1'b1; cfg_addr = 4'b0101; cfg_wdata = 16'd2;
        ifetch_valid = 1'b1; ifetch_addr = 16'h300;
        tick();
        cfg_we = 1'b0; ifetch_valid = 1'b0;
        chk("R4 match during write not counted", int'(evt_hit), 0);
        fetch('h300);
        chk("R4 one after write", int'(evt_hit), 0);
        fetch('h300);
        chk("R4 two after write fires", int'(evt_hit), 1);
        cfg(1, 1, 0);
        fetch('h300);
        chk("R3 N of zero acts as one", int'(evt_hit), 1);
        fetch('h300);
        chk("R3 N of zero fires each match", int'(evt_hit), 1);

        // Halted state ignores strobes
        cfg(1, 1, 2);
        debug_req = 1'b1;
        tick();
        debug_req = 1'b0;
        chk("R8 debug request halts", int'(halted), 1);
        fetch('h300);
        chk("R9 no event while halted", int'(evt_hit), 0);
        fetch('h300);
        br_taken = 1'b1;
        tick();
        br_taken = 1'b0;
        chk("R9 no trace while halted", int'(trc_valid), 0);
        pulse_resume();
        fetch('h300);
        chk("R9 halted matches not counted", int'(evt_hit), 0);
        fetch('h300);
        chk("R9 counting resumes after halt", int'(evt_hit), 1);

        // Trace records
        br_taken = 1'b1;
        tick();
        br_taken = 1'b0;
        chk("R10 branch emits record", int'(trc_valid), 1);
        repeat (5) fetch('h500);
        ifetch_valid = 1'b1; ifetch_addr = 16'h500; br_taken = 1'b1;
        tick();
        ifetch_valid = 1'b0; br_taken = 1'b0;
        chk("R10 record valid", int'(trc_valid), 1);
        chk("R10 count includes branch cycle", int'(trc_count), 6);
        chk("R10 branch flag", int'(trc_exc), 0);
        repeat (2) fetch('h500);
        exc_taken = 1'b1;
        tick();
        exc_taken = 1'b0;
        chk("R10 exception count", int'(trc_count), 2);
        chk("R10 exception flag", int'(trc_exc), 1);
        br_taken = 1'b1; exc_taken = 1'b1;
        tick();
        br_taken = 1'b0; exc_taken = 1'b0;
        chk("R10 count cleared after record", int'(trc_count), 0);
        chk("R10 exception wins", int'(trc_exc), 1);
        ifetch_valid = 1'b1; ifetch_addr = 16'h500;
        repeat (1100) tick();
        ifetch_valid = 1'b0;
        br_taken = 1'b1;
        tick();
        br_taken = 1'b0;
        chk("R10 count saturates", int'(trc_count), CMAX);

        // Field 3 and index 3 writes ignored
        cfg(0, 3, 0);
        cfg(3, 2, 0);
        fetch('h100);
        fetch('h100);
        fetch('h100);
        chk("R2 reserved writes leave comparator 0 armed", int'(evt_hit), 1);
        chk("R5 breakpoint halts again", int'(halted), 1);

        // Request priority over resume
        debug_req = 1'b1; resume = 1'b1;
        tick();
        debug_req = 1'b0; resume = 1'b0;
        chk("R8 debug request beats resume", int'(halted), 1);
        pulse_resume();
        chk("R8 resume runs", int'(halted), 0);
        pulse_resume();
        chk("R8 resume while running ignored", int'(halted), 0);

        // Reset without halt strap
        reset_halt_en = 1'b0;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 runs out of reset without strap", int'(halted), 0);
        fetch('h100);
        chk("R1 reset disables comparators", int'(evt_hit), 0);
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule